// File: doc/BRIEF.md
# Multi-Format Sample Output Formatter

This block sits at the tail of a decimating receive filter chain. It turns a pair of wide signed results, one in-phase (I) and one quadrature (Q), into the word format a downstream consumer asks for. Each lane takes a 38-bit two's-complement sample.

The sample can leave the block in one of two forms:

- A fixed-point word of 16, 24, 32 or 38 bits, coded as two's complement, signed magnitude or offset binary.
- An IEEE-754 single-precision value.

The result is right-aligned on a 38-bit bus. A valid strobe marks each result.

The configuration pins are sampled together with each input sample. The configuration can therefore change on any cycle without disturbing samples already in the pipeline. Both lanes always use the same configuration and the same latency.

Top module: `sample_out_formatter`

## Requirements
- R1: A result appears exactly two clock cycles after its input sample. `out_valid` equals `in_valid` delayed by two cycles.
- R2: With `cfg_float`=0 and `cfg_code`=0 (two's complement), the output holds the W most significant bits of the input in bits W-1:0, and every bit above W-1 is zero. W is set by `cfg_width`: 0=16, 1=24, 2=32, 3=38.
- R3: Code value 3 on `cfg_code` is treated exactly like code 0 (two's complement).
- R4: With `cfg_code`=1 (signed magnitude), bit W-1 is the sign and bits W-2:0 are the magnitude of the truncated W-bit value. A truncated value of -2^(W-1) saturates to magnitude 2^(W-1)-1. The pattern "sign set, magnitude zero" never appears.
- R5: With `cfg_code`=2 (offset binary), the output is the truncated W-bit two's-complement word with bit W-1 inverted.
- R6: With `cfg_float`=1, width and code are ignored. The input is read as a fraction with the binary point just below bit 37. The output bits 31:0 hold an IEEE single:
  - sign = input bit 37;
  - exponent = 90 + position of the leading one of |x|;
  - mantissa = the 23 bits below that leading one, truncated.
  Bits 37:32 are zero.
- R7: In floating-point mode an input of zero gives an all-zero output (+0.0).
- R8: The I and Q lanes apply the same conversion, each to its own input.
- R9: Configuration is captured with each sample. A change of configuration affects only samples presented in that cycle or later.
- R10: Synchronous active-high reset clears `out_valid`, `out_i` and `out_q` to zero by the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_float | input | 1 | 1 selects single-precision float output |
| cfg_width | input | 2 | Fixed-point width: 0=16, 1=24, 2=32, 3=38 bits |
| cfg_code | input | 2 | Fixed-point coding: 0 two's complement, 1 signed magnitude, 2 offset binary, 3 as 0 |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 38 | In-phase sample, two's complement |
| in_q | input | 38 | Quadrature sample, two's complement |
| out_valid | output | 1 | Result strobe |
| out_i | output | 38 | Formatted in-phase word, right-aligned |
| out_q | output | 38 | Formatted quadrature word, right-aligned |

## Verification
The embedded properties check several things on every cycle:
- the two-stage valid timing;
- the zero fill above the chosen fixed-point width;
- the absence of a negative-zero code in signed magnitude;
- the inverted top bit in offset binary;
- the float exponent range and the +0.0 result for a zero input;
- the lockstep of the two lanes.

Some behaviour only the bench scenarios can show:
- exact bit values against the behavioural model;
- saturation of the most negative truncated value;
- mantissa truncation;
- the aliasing of code 3;
- per-sample capture of a configuration that changes every cycle;
- the return to zero after a reset in mid-stream.

// File: rtl/ofmt_pkg.sv
package ofmt_pkg;

    localparam int unsigned DATA_W   = 38;
    localparam int unsigned POS_W    = $clog2(DATA_W);
    localparam int unsigned FLT_W    = 32;
    localparam int unsigned MANT_W   = 23;
    localparam int unsigned EXP_W    = 8;
    localparam int unsigned EXP_BIAS = 127;
    localparam int unsigned EXP_BASE = EXP_BIAS - (DATA_W - 1);
    localparam int unsigned LANES    = 2;

    typedef enum logic [1:0] {
        WSEL_16   = 2'd0,
        WSEL_24   = 2'd1,
        WSEL_32   = 2'd2,
        WSEL_FULL = 2'd3
    } wsel_e;

    typedef enum logic [1:0] {
        CODE_TWOS = 2'd0,
        CODE_SMAG = 2'd1,
        CODE_OFFS = 2'd2,
        CODE_ALT  = 2'd3
    } code_e;

    typedef struct packed {
        logic  use_float;
        wsel_e wsel;
        code_e code;
    } fmt_cfg_t;

    typedef struct packed {
        fmt_cfg_t          cfg;
        logic [DATA_W-1:0] trunc;
        logic              neg;
        logic [DATA_W-1:0] mag;
    } prep_t;

    function automatic int unsigned word_bits(wsel_e w);
        case (w)
            WSEL_16:   return 16;
            WSEL_24:   return 24;
            WSEL_32:   return 32;
            default:   return DATA_W;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] low_mask(int unsigned n);
        logic [DATA_W:0] m;
        m = ((DATA_W+1)'(1) << n) - (DATA_W+1)'(1);
        return m[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/ofmt_lead_one.sv
module ofmt_lead_one
    import ofmt_pkg::*;
(
    input  logic [DATA_W-1:0] vec,
    output logic [POS_W-1:0]  pos,
    output logic              found
);
    always_comb begin
        pos   = '0;
        found = 1'b0;
        for (int b = 0; b < int'(DATA_W); b++) begin
            if (vec[b]) begin
                pos   = POS_W'(b);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ofmt_prep.sv
module ofmt_prep
    import ofmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  fmt_cfg_t          cfg_in,
    input  logic [DATA_W-1:0] din,
    output logic              s1_valid,
    output prep_t             s1
);
    logic signed [DATA_W-1:0] sdin;
    logic [DATA_W-1:0]        trunc_c;
    logic [DATA_W-1:0]        mag_c;
    int unsigned              shift_c;

    assign sdin = din;

    always_comb begin
        shift_c = DATA_W - word_bits(cfg_in.wsel);
        trunc_c = sdin >>> shift_c;
        mag_c   = din[DATA_W-1] ? (~din + DATA_W'(1)) : din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1       <= '0;
        end else begin
            s1_valid  <= in_valid;
            s1.cfg    <= cfg_in;
            s1.trunc  <= trunc_c;
            s1.neg    <= din[DATA_W-1];
            s1.mag    <= mag_c;
        end
    end

    AST_S1_TAKES_SAMPLE: assert property (@(posedge clk) disable iff (rst) in_valid |=> s1_valid); // R1
    AST_S1_IDLE_GAP: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !s1_valid); // R1
endmodule

// File: rtl/ofmt_encode.sv
module ofmt_encode
    import ofmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              s1_valid,
    input  prep_t             s1,
    output logic              out_valid,
    output logic [DATA_W-1:0] word
);
    int unsigned       wbits;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] topbit;
    logic [DATA_W-1:0] tmag;
    logic [DATA_W-1:0] twos_w;
    logic [DATA_W-1:0] smag_w;
    logic [DATA_W-1:0] offs_w;
    logic [DATA_W-1:0] flt_w;
    logic [DATA_W-1:0] norm;
    logic [POS_W-1:0]  lead_pos;
    logic              lead_found;
    logic [EXP_W-1:0]  expo;
    logic [FLT_W-1:0]  flt32;
    logic [DATA_W-1:0] next_word;

    ofmt_lead_one u_lead (
        .vec   (s1.mag),
        .pos   (lead_pos),
        .found (lead_found)
    );

    always_comb begin
        wbits  = word_bits(s1.cfg.wsel);
        mask   = low_mask(wbits);
        topbit = DATA_W'(1) << (wbits - 1);
        tmag   = ~s1.trunc + DATA_W'(1);
        twos_w = s1.trunc & mask;
        if (s1.trunc[DATA_W-1])
            smag_w = topbit | ((tmag >= topbit) ? (topbit - DATA_W'(1)) : tmag);
        else
            smag_w = twos_w;
        offs_w = (s1.trunc ^ topbit) & mask;

        norm  = s1.mag << (POS_W'(DATA_W - 1) - lead_pos);
        expo  = EXP_W'(EXP_BASE + 32'(lead_pos));
        flt32 = {s1.neg, expo, norm[DATA_W-2 -: MANT_W]};
        flt_w = lead_found ? DATA_W'(flt32) : '0;

        if (s1.cfg.use_float)
            next_word = flt_w;
        else begin
            case (s1.cfg.code)
                CODE_SMAG: next_word = smag_w;
                CODE_OFFS: next_word = offs_w;
                default:   next_word = twos_w;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            word      <= '0;
        end else begin
            out_valid <= s1_valid;
            word      <= next_word;
        end
    end

    AST_OUT_TAKES_S1: assert property (@(posedge clk) disable iff (rst) s1_valid |=> out_valid); // R1
    AST_OUT_IDLE_GAP: assert property (@(posedge clk) disable iff (rst) !s1_valid |=> !out_valid); // R1
    AST_FIXED_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst) (s1_valid && !s1.cfg.use_float) |=> ((word & ~$past(mask)) == '0)); // R2
    AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (rst) (s1_valid && !s1.cfg.use_float && s1.cfg.code == CODE_SMAG) |=> (word != $past(topbit))); // R4
    AST_OFFS_SIGN_FLIP: assert property (@(posedge clk) disable iff (rst) (s1_valid && !s1.cfg.use_float && s1.cfg.code == CODE_OFFS) |=> (((word & $past(topbit)) != '0) == !$past(s1.trunc[DATA_W-1]))); // R5
    AST_FLOAT_EXP_RANGE: assert property (@(posedge clk) disable iff (rst) (s1_valid && s1.cfg.use_float && s1.mag != '0) |=> (word[DATA_W-1:FLT_W] == '0 && word[30:23] >= EXP_W'(EXP_BASE) && word[30:23] <= EXP_W'(EXP_BIAS))); // R6
    AST_FLOAT_ZERO: assert property (@(posedge clk) disable iff (rst) (s1_valid && s1.cfg.use_float && s1.mag == '0) |=> (word == '0)); // R7
endmodule

// File: rtl/sample_out_formatter.sv
module sample_out_formatter
    import ofmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_float,
    input  logic [1:0]        cfg_width,
    input  logic [1:0]        cfg_code,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_i,
    input  logic [DATA_W-1:0] in_q,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_i,
    output logic [DATA_W-1:0] out_q
);
    fmt_cfg_t          cfg_c;
    logic [DATA_W-1:0] lane_in   [LANES];
    logic [DATA_W-1:0] lane_out  [LANES];
    logic              lane_vld  [LANES];

    assign cfg_c.use_float = cfg_float;
    assign cfg_c.wsel      = wsel_e'(cfg_width);
    assign cfg_c.code      = code_e'(cfg_code);

    assign lane_in[0] = in_i;
    assign lane_in[1] = in_q;

    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        logic  s1_valid;
        prep_t s1;

        ofmt_prep u_prep (
            .clk      (clk),
            .rst      (rst),
            .in_valid (in_valid),
            .cfg_in   (cfg_c),
            .din      (lane_in[g]),
            .s1_valid (s1_valid),
            .s1       (s1)
        );

        ofmt_encode u_enc (
            .clk       (clk),
            .rst       (rst),
            .s1_valid  (s1_valid),
            .s1        (s1),
            .out_valid (lane_vld[g]),
            .word      (lane_out[g])
        );
    end

    assign out_valid = lane_vld[0];
    assign out_i     = lane_out[0];
    assign out_q     = lane_out[1];

    AST_LANES_LOCKSTEP: assert property (@(posedge clk) disable iff (rst) lane_vld[0] == lane_vld[1]); // R8
endmodule

// File: tb/sample_out_formatter_bench.sv
`timescale 1ns/1ps
module sample_out_formatter_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_float = 1'b0;
    logic [1:0]  cfg_width = 2'd0;
    logic [1:0]  cfg_code = 2'd0;
    logic        in_valid = 1'b0;
    logic [37:0] in_i = '0;
    logic [37:0] in_q = '0;
    logic        out_valid;
    logic [37:0] out_i;
    logic [37:0] out_q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    string phase = "";

    typedef struct {
        bit          v;
        logic [37:0] ei;
        logic [37:0] eq;
        string       ri;
        string       rq;
    } exp_t;

    exp_t pipe[$];

    always #5 clk = ~clk;

    sample_out_formatter u_sample_out_formatter (
        .clk(clk), .rst(rst), .cfg_float(cfg_float), .cfg_width(cfg_width),
        .cfg_code(cfg_code), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    function automatic logic [37:0] fmt_ref(logic [37:0] x, bit fl, int w, int c);
        longint xv, t, top, mask, r, m;
        int     nb, p;
        bit     s;
        xv   = longint'($signed(x));
        nb   = (w == 3) ? 38 : 16 + 8 * w;
        t    = xv >>> (38 - nb);
        top  = longint'(1) << (nb - 1);
        mask = (longint'(1) << nb) - 1;
        r    = 0;
        if (fl) begin
            if (xv != 0) begin
                s = (xv < 0);
                m = s ? -xv : xv;
                p = 0;
                for (int b = 0; b < 38; b++) if (((m >> b) & 1) == 1) p = b;
                r = (longint'(s) << 31) | (longint'(90 + p) << 23)
                    | (((m << (37 - p)) >> 14) & 64'h7F_FFFF);
            end
        end else if (c == 1) begin
            if (t < 0) begin
                m = -t;
                if (m > top - 1) m = top - 1;
                r = top | m;
            end else r = t;
        end else if (c == 2) begin
            r = (t ^ top) & mask;
        end else begin
            r = t & mask;
        end
        return r[37:0];
    endfunction

    function automatic string req_of(logic [37:0] x, bit fl, int c);
        if (fl) return (x == '0) ? "R7" : "R6";
        case (c)
            1: return "R4";
            2: return "R5";
            3: return "R3";
            default: return "R2";
        endcase
    endfunction

    task automatic fail_line(string req, logic [37:0] act, logic [37:0] exp_v);
        n_fail++;
        $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp_v, $time);
    endtask

    task automatic cycle(bit v, logic [37:0] xi, logic [37:0] xq, bit fl, int w, int c);
        exp_t e, n;
        @(negedge clk);
        e = pipe.pop_front();
        n_chk++;
        if (out_valid !== e.v) fail_line("R1", 38'(out_valid), 38'(e.v));
        if (e.v) begin
            n_chk++;
            if (out_i !== e.ei) fail_line(e.ri, out_i, e.ei);
            n_chk++;
            if (out_q !== e.eq) fail_line(e.rq, out_q, e.eq);
        end
        in_valid  = v;
        in_i      = xi;
        in_q      = xq;
        cfg_float = fl;
        cfg_width = 2'(w);
        cfg_code  = 2'(c);
        n.v  = v;
        n.ei = fmt_ref(xi, fl, w, c);
        n.eq = fmt_ref(xq, fl, w, c);
        n.ri = {phase, req_of(xi, fl, c)};
        n.rq = {"R8 ", phase, req_of(xq, fl, c)};
        pipe.push_back(n);
    endtask

    task automatic prime_pipe();
        exp_t z;
        z.v = 1'b0; z.ei = '0; z.eq = '0; z.ri = "R1"; z.rq = "R1";
        pipe.delete();
        pipe.push_back(z);
        pipe.push_back(z);
    endtask

    task automatic check_reset_state();
        n_chk++; if (out_valid !== 1'b0) fail_line("R10", 38'(out_valid), '0);
        n_chk++; if (out_i !== '0) fail_line("R10", out_i, '0);
        n_chk++; if (out_q !== '0) fail_line("R10", out_q, '0);
    endtask

    function automatic logic [37:0] rnd38();
        logic [63:0] r;
        r = {$urandom(), $urandom()};
        return 38'($signed(r[37:0]) >>> ($urandom() % 38));
    endfunction

    logic [37:0] dvec [9] = '{
        38'h00_0000_0000, 38'h00_0000_0001, 38'h3F_FFFF_FFFF,
        38'h1F_FFFF_FFFF, 38'h20_0000_0000, 38'h20_0000_1234,
        38'h1F_FFFF_0000, 38'h00_0123_4567, 38'h3F_FF80_0001
    };

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        prime_pipe();

        phase = "";
        for (int f = 0; f < 2; f++)
            for (int w = 0; w < 4; w++)
                for (int c = 0; c < 4; c++) begin
                    for (int k = 0; k < 9; k++)
                        cycle(1'b1, dvec[k], dvec[(k + 4) % 9], f[0], w, c);
                    cycle(1'b0, '0, '0, f[0], w, c);
                end

        phase = "R9 ";
        for (int k = 0; k < 3000; k++)
            cycle(($urandom() % 4) != 0, rnd38(), rnd38(), $urandom() % 2 == 0,
                  int'($urandom() % 4), int'($urandom() % 4));

        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        check_reset_state();
        @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        in_valid = 1'b0;
        prime_pipe();

        for (int k = 0; k < 300; k++)
            cycle(($urandom() % 3) != 0, rnd38(), rnd38(), $urandom() % 2 == 0,
                  int'($urandom() % 4), int'($urandom() % 4));
        repeat (3) cycle(1'b0, '0, '0, 1'b0, 0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule